// File: doc/BRIEF.md
# Capture-to-DMA Request Buffer

This block connects one pair of capture channels to a DMA controller. The channel gives a strobe and a 16-bit captured value for each rising edge, and another strobe and value for each falling edge. When an edge type that software has selected is captured, the block copies the value into a single output buffer and raises a request line. The request stays high, and the buffer keeps its value, until the DMA controller returns an acknowledge to show that it has read the buffer.

A 2-bit mode field chooses what is forwarded: nothing, rising-edge values only, falling-edge values only, or both. In both-edge mode an order bit decides which edge opens a pair. The block waits for that opening edge and places its value in the buffer. It then takes the next capture of the other edge into a staging register. That second value goes to the buffer with a fresh request one cycle after the request line falls.

A capture that should have been taken but finds its destination still occupied is dropped, and this sets a sticky overrun flag. Clearing the enable input withdraws any request and drops any staged value. It also clears the overrun flag.

Top module: `capt_dma_buf`

## Requirements
- R1: While `en` is low at a clock edge, `dma_req` is low after that edge, any staged value is discarded, `ovr_flag` clears and every strobe is ignored.
- R2: With `mode` = 2'b01 (rising only), a `rise_stb` that arrives while no request is pending loads `rise_val` into `buf_val` and sets `dma_req` after that same edge; `fall_stb` has no effect.
- R3: With `mode` = 2'b10 (falling only), a `fall_stb` that arrives while no request is pending loads `fall_val` into `buf_val` and sets `dma_req` after that same edge; `rise_stb` has no effect.
- R4: While `dma_req` is high and `dma_ack` is low, `dma_req` stays high and `buf_val` does not change.
- R5: An edge that samples `dma_ack` high while `dma_req` is high leaves `dma_req` low; an `dma_ack` that arrives while `dma_req` is low has no effect.
- R6: With `mode` = 2'b00, no strobe raises `dma_req`.
- R7: With `mode` = 2'b11 and `order` = 0, a rising capture opens a pair. The next falling capture goes into staging. After the first acknowledge, `dma_req` is low for exactly one cycle and then rises again with the falling value in `buf_val`.
- R8: With `mode` = 2'b11 and `order` = 1, a falling capture opens the pair and the rising value is forwarded second.
- R9: In both-edge mode, if the second capture arrives after the first value has been acknowledged, `dma_req` rises one cycle after that capture's strobe edge and carries its value.
- R10: A selected capture that arrives while its destination is occupied leaves `buf_val` unchanged and sets `ovr_flag`. The flag stays set through later acknowledges until `en` goes low.
- R11: In both-edge mode, a strobe of the edge type not currently expected is ignored and does not set `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables request generation |
| mode | input | 2 | 00 none, 01 rising, 10 falling, 11 both |
| order | input | 1 | Both-edge mode: 0 rising first, 1 falling first |
| rise_stb | input | 1 | Rising-edge capture strobe |
| rise_val | input | DW | Rising-edge captured value |
| fall_stb | input | 1 | Falling-edge capture strobe |
| fall_val | input | DW | Falling-edge captured value |
| dma_ack | input | 1 | DMA acknowledge, buffer has been read |
| dma_req | output | 1 | DMA request |
| buf_val | output | DW | Buffer contents offered to the DMA |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
A strobe that lands directly in the buffer makes `dma_req` and `buf_val` visible after the same edge that samples it. An acknowledge lowers `dma_req` after the edge that samples it. A value held in staging needs one more edge: it appears with its request one cycle after the request line is low. The bench drives every input on the falling clock edge and holds it across exactly one rising edge. It checks on the next falling edge, and for staged values it waits one extra cycle, first checking that the request line is low in the gap and then checking the second value.

// File: rtl/capt_dma_buf.sv
module capt_dma_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic          order,
  input  logic          rise_stb,
  input  logic [DW-1:0] rise_val,
  input  logic          fall_stb,
  input  logic [DW-1:0] fall_val,
  input  logic          dma_ack,
  output logic          dma_req,
  output logic [DW-1:0] buf_val,
  output logic          ovr_flag
);

  localparam logic [1:0] M_RISE = 2'b01;
  localparam logic [1:0] M_FALL = 2'b10;
  localparam logic [1:0] M_BOTH = 2'b11;

  logic          second_ph;
  logic [DW-1:0] stage_q;
  logic          stage_vld;

  logic          both;
  logic          want_rise, want_fall;
  logic          hit, to_stage, busy, take;
  logic [DW-1:0] hit_val;

  assign both      = (mode == M_BOTH);
  assign want_rise = (mode == M_RISE) | (both & (second_ph ? order : ~order));
  assign want_fall = (mode == M_FALL) | (both & (second_ph ? ~order : order));
  assign hit       = en & ((want_rise & rise_stb) | (want_fall & fall_stb));
  assign hit_val   = (want_rise & rise_stb) ? rise_val : fall_val;
  assign to_stage  = both & second_ph;
  assign busy      = to_stage ? stage_vld : (dma_req | stage_vld);
  assign take      = hit & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req   <= 1'b0;
      buf_val   <= '0;
      ovr_flag  <= 1'b0;
      second_ph <= 1'b0;
      stage_q   <= '0;
      stage_vld <= 1'b0;
    end else if (!en) begin
      dma_req   <= 1'b0;
      ovr_flag  <= 1'b0;
      second_ph <= 1'b0;
      stage_vld <= 1'b0;
    end else begin
      if (dma_req && dma_ack) begin
        dma_req <= 1'b0;
      end else if (!dma_req && stage_vld) begin
        buf_val   <= stage_q;
        dma_req   <= 1'b1;
        stage_vld <= 1'b0;
      end

      if (take && !to_stage) begin
        buf_val   <= hit_val;
        dma_req   <= 1'b1;
        second_ph <= both;
      end else if (take && to_stage) begin
        stage_q   <= hit_val;
        stage_vld <= 1'b1;
        second_ph <= 1'b0;
      end else if (!both) begin
        second_ph <= 1'b0;
      end

      if (hit && busy)
        ovr_flag <= 1'b1;
    end
  end

endmodule

module capt_dma_buf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dma_ack,
  input logic          dma_req,
  input logic [DW-1:0] buf_val,
  input logic          ovr_flag
);

  a_r1_disable_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dma_req);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_req && !dma_ack) |=> (dma_req && $stable(buf_val)));

  a_r5_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> !dma_req);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovr_flag) |=> ovr_flag);

endmodule

bind capt_dma_buf capt_dma_buf_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .dma_ack(dma_ack),
  .dma_req(dma_req), .buf_val(buf_val), .ovr_flag(ovr_flag)
);

// File: tb/capt_dma_buf_tb_top.sv
module capt_dma_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          order = 1'b0;
  logic          rise_stb = 1'b0;
  logic [DW-1:0] rise_val = '0;
  logic          fall_stb = 1'b0;
  logic [DW-1:0] fall_val = '0;
  logic          dma_ack = 1'b0;
  logic          dma_req;
  logic [DW-1:0] buf_val;
  logic          ovr_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_dma_buf #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .order(order),
    .rise_stb(rise_stb), .rise_val(rise_val),
    .fall_stb(fall_stb), .fall_val(fall_val),
    .dma_ack(dma_ack), .dma_req(dma_req), .buf_val(buf_val), .ovr_flag(ovr_flag)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic p_rise(logic [DW-1:0] v);
    @(negedge clk); rise_stb = 1'b1; rise_val = v;
    @(negedge clk); rise_stb = 1'b0;
  endtask

  task automatic p_fall(logic [DW-1:0] v);
    @(negedge clk); fall_stb = 1'b1; fall_val = v;
    @(negedge clk); fall_stb = 1'b0;
  endtask

  task automatic p_ack();
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
  endtask

  task automatic restart(logic [1:0] m, logic o);
    @(negedge clk); en = 1'b0; mode = m; order = o;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_reset();
    check("R1", "reset req", dma_req, 0);
    check("R1", "reset ovr", ovr_flag, 0);
    check("R1", "reset buf", buf_val, 0);
  endtask

  task automatic t_rise_only();
    restart(2'b01, 1'b0);
    p_fall(16'hAAAA);
    check("R2", "fall ignored req", dma_req, 0);
    p_rise(16'h1234);
    check("R2", "req", dma_req, 1);
    check("R2", "buf", buf_val, 16'h1234);
    idle(3);
    check("R4", "held req", dma_req, 1);
    check("R4", "held buf", buf_val, 16'h1234);
    p_ack();
    check("R5", "req after ack", dma_req, 0);
    p_ack();
    check("R5", "stray ack", dma_req, 0);
    check("R5", "stray ack buf", buf_val, 16'h1234);
  endtask

  task automatic t_fall_only();
    restart(2'b10, 1'b0);
    p_rise(16'hBBBB);
    check("R3", "rise ignored req", dma_req, 0);
    p_fall(16'h5678);
    check("R3", "req", dma_req, 1);
    check("R3", "buf", buf_val, 16'h5678);
    p_ack();
    check("R3", "req after ack", dma_req, 0);
  endtask

  task automatic t_none();
    restart(2'b00, 1'b0);
    p_rise(16'h0101);
    p_fall(16'h0202);
    idle(1);
    check("R6", "no req", dma_req, 0);
    check("R6", "buf kept", buf_val, 16'h5678);
  endtask

  task automatic t_both_rise_first();
    restart(2'b11, 1'b0);
    p_fall(16'h0F0F);
    check("R11", "unexpected fall req", dma_req, 0);
    check("R11", "unexpected fall ovr", ovr_flag, 0);
    p_rise(16'h1111);
    check("R7", "first req", dma_req, 1);
    check("R7", "first buf", buf_val, 16'h1111);
    p_rise(16'h9999);
    check("R11", "rise in second phase ovr", ovr_flag, 0);
    check("R11", "rise in second phase buf", buf_val, 16'h1111);
    p_fall(16'h2222);
    check("R7", "buf still first", buf_val, 16'h1111);
    p_ack();
    check("R7", "gap cycle req", dma_req, 0);
    idle(1);
    check("R7", "second req", dma_req, 1);
    check("R7", "second buf", buf_val, 16'h2222);
    p_ack();
    check("R7", "done req", dma_req, 0);
  endtask

  task automatic t_both_fall_first_late();
    restart(2'b11, 1'b1);
    p_rise(16'h4040);
    check("R8", "rise ignored first", dma_req, 0);
    p_fall(16'h3333);
    check("R8", "first req", dma_req, 1);
    check("R8", "first buf", buf_val, 16'h3333);
    p_ack();
    idle(1);
    check("R9", "no req before second", dma_req, 0);
    p_rise(16'h4444);
    check("R9", "staged, req low", dma_req, 0);
    idle(1);
    check("R9", "second req", dma_req, 1);
    check("R9", "second buf", buf_val, 16'h4444);
    p_ack();
  endtask

  task automatic t_overrun();
    restart(2'b01, 1'b0);
    p_rise(16'h5555);
    p_rise(16'h6666);
    check("R10", "buf kept", buf_val, 16'h5555);
    check("R10", "ovr set", ovr_flag, 1);
    p_ack();
    check("R10", "ovr sticky", ovr_flag, 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1", "ovr cleared", ovr_flag, 0);
    en = 1'b1;
  endtask

  task automatic t_disable();
    restart(2'b01, 1'b0);
    p_rise(16'h7777);
    check("R1", "req before disable", dma_req, 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1", "req withdrawn", dma_req, 0);
    rise_stb = 1'b1; rise_val = 16'h8888;
    @(negedge clk); rise_stb = 1'b0;
    check("R1", "strobe ignored req", dma_req, 0);
    check("R1", "strobe ignored buf", buf_val, 16'h7777);
    en = 1'b1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_rise_only();
    t_fall_only();
    t_none();
    t_both_rise_first();
    t_both_fall_first_late();
    t_overrun();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule